// File: doc/BRIEF.md
# Register Bus Window Decoder

This block lets one upstream register bus reach several downstream register buses, each typically owned by a single peripheral's register multiplexer. Every downstream port gets a fixed window of the upstream address space. All windows have the same power-of-two size, and each base address is set by a parameter. The upstream port and every downstream port use the same five signals: an address, a read strobe, read data, a write strobe and write data. All of them share one data width, so no width conversion takes place.

The decoder is purely combinational. A read or write strobe reaches only the downstream port whose window holds the upstream address. That port receives the address with the window base removed. Write data goes to every downstream port. Read data coming back is merged with a bitwise OR. This is correct because a downstream port that was not read in the previous cycle returns zero, so the return path needs no registered select. A subordinate that answers one cycle after its strobe therefore appears upstream with that same one-cycle latency. An address that falls outside every window raises no downstream strobe, and a read there returns zero.

Top module: `regdec_top`

## Requirements
- R1: When `up_r_stb` is high and `up_addr` lies in window i, `sub_r_stb` bit i is high and every other bit is low. When `up_r_stb` is low, all `sub_r_stb` bits are low. Window i spans `SUB_BASE[i]` to `SUB_BASE[i] + 2**WIN_AW - 1`, with defaults 0x0000 (port 0) and 0x1000 (port 1).
- R2: `sub_w_stb` follows the same rule as R1, driven by `up_w_stb`.
- R3: The address field of port i in `sub_addr` (bits `[i*WIN_AW +: WIN_AW]`) equals `up_addr` minus the base of window i whenever `up_addr` lies in window i.
- R4: Every `DATA_W` slice of `sub_w_data` equals `up_w_data`.
- R5: For an address outside every window (with defaults, 0x2000 and above), no downstream strobe is raised, no subordinate state changes, and a read returns zero upstream in the following cycle.
- R6: `up_r_data` is the bitwise OR of all slices of `sub_r_data` in the same cycle, and it is zero when all slices are zero. The decoder adds no cycle, so a registered subordinate's read value appears upstream exactly one cycle after `up_r_stb`.
- R7: At most one downstream read strobe and at most one downstream write strobe are high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_addr | input | ADDR_W | Upstream address |
| up_r_stb | input | 1 | Upstream read strobe |
| up_w_stb | input | 1 | Upstream write strobe |
| up_w_data | input | DATA_W | Upstream write data |
| up_r_data | output | DATA_W | Merged read data returned upstream |
| sub_addr | output | NUM_SUB*WIN_AW | Offset within the window, one field per downstream port |
| sub_r_stb | output | NUM_SUB | Read strobe, one bit per downstream port |
| sub_w_stb | output | NUM_SUB | Write strobe, one bit per downstream port |
| sub_w_data | output | NUM_SUB*DATA_W | Write data copied to each downstream port |
| sub_r_data | input | NUM_SUB*DATA_W | Read data from each downstream port |

## Verification
The strobes, offsets and write data are combinational, so they are due in the same cycle as the upstream request. The bench checks them one time unit after it drives the inputs, well before the next rising edge. The two register stubs latch read data on that rising edge, so merged read data is due one cycle after the strobe. The bench compares it at the following falling edge against the value predicted by its own model, and expects zero after an unmapped or idle cycle.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

    // Upper bound on the address width that the match function handles
    localparam int MAX_AW = 32;

    // True when addr and base agree on every bit from win_aw up to addr_w-1
    function automatic logic win_match(
        input logic [MAX_AW-1:0] addr,
        input logic [MAX_AW-1:0] base,
        input int                win_aw,
        input int                addr_w
    );
        logic [2*MAX_AW-1:0] upper_mask;
        logic [2*MAX_AW-1:0] diff;
        upper_mask = ((64'd1 << addr_w) - 64'd1) & ~((64'd1 << win_aw) - 64'd1);
        diff       = {32'd0, addr ^ base};
        return (diff & upper_mask) == 64'd0;
    endfunction

endpackage

// File: rtl/regdec_window.sv
module regdec_window #(
    parameter int                ADDR_W = 16,
    parameter int                WIN_AW = 12,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_r_stb,
    input  logic              up_w_stb,
    output logic              r_stb,
    output logic              w_stb,
    output logic [WIN_AW-1:0] offset
);
    logic hit;

    always_comb begin
        hit    = regdec_pkg::win_match(32'(up_addr), 32'(BASE), WIN_AW, ADDR_W);
        r_stb  = hit & up_r_stb;
        w_stb  = hit & up_w_stb;
        // Aligned window: removing the base leaves the low address bits
        offset = up_addr[WIN_AW-1:0];
    end
endmodule

// File: rtl/regdec_rdata_or.sv
module regdec_rdata_or #(
    parameter int DATA_W = 8,
    parameter int NUM_IN = 2
) (
    input  logic [NUM_IN*DATA_W-1:0] in_data,
    output logic [DATA_W-1:0]        out_data
);
    always_comb begin
        out_data = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            out_data = out_data | in_data[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/regdec_top.sv
module regdec_top #(
    parameter int                        ADDR_W   = 16,
    parameter int                        DATA_W   = 8,
    parameter int                        NUM_SUB  = 2,
    parameter int                        WIN_AW   = 12,
    parameter logic [NUM_SUB*ADDR_W-1:0] SUB_BASE = 32'h1000_0000
) (
    input  logic [ADDR_W-1:0]         up_addr,
    input  logic                      up_r_stb,
    input  logic                      up_w_stb,
    input  logic [DATA_W-1:0]         up_w_data,
    output logic [DATA_W-1:0]         up_r_data,
    output logic [NUM_SUB*WIN_AW-1:0] sub_addr,
    output logic [NUM_SUB-1:0]        sub_r_stb,
    output logic [NUM_SUB-1:0]        sub_w_stb,
    output logic [NUM_SUB*DATA_W-1:0] sub_w_data,
    input  logic [NUM_SUB*DATA_W-1:0] sub_r_data
);
    for (genvar i = 0; i < NUM_SUB; i++) begin : g_win
        localparam logic [ADDR_W-1:0] WBASE = SUB_BASE[i*ADDR_W +: ADDR_W];

        regdec_window #(
            .ADDR_W(ADDR_W),
            .WIN_AW(WIN_AW),
            .BASE  (WBASE)
        ) u_win (
            .up_addr (up_addr),
            .up_r_stb(up_r_stb),
            .up_w_stb(up_w_stb),
            .r_stb   (sub_r_stb[i]),
            .w_stb   (sub_w_stb[i]),
            .offset  (sub_addr[i*WIN_AW +: WIN_AW])
        );

        assign sub_w_data[i*DATA_W +: DATA_W] = up_w_data;
    end

    regdec_rdata_or #(
        .DATA_W(DATA_W),
        .NUM_IN(NUM_SUB)
    ) u_or (
        .in_data (sub_r_data),
        .out_data(up_r_data)
    );
endmodule

// File: rtl/regdec_checker.sv
module regdec_checker #(
    parameter int                        ADDR_W   = 16,
    parameter int                        DATA_W   = 8,
    parameter int                        NUM_SUB  = 2,
    parameter int                        WIN_AW   = 12,
    parameter logic [NUM_SUB*ADDR_W-1:0] SUB_BASE = 32'h1000_0000
) (
    input logic [ADDR_W-1:0]         up_addr,
    input logic                      up_r_stb,
    input logic                      up_w_stb,
    input logic [DATA_W-1:0]         up_r_data,
    input logic [NUM_SUB*WIN_AW-1:0] sub_addr,
    input logic [NUM_SUB-1:0]        sub_r_stb,
    input logic [NUM_SUB-1:0]        sub_w_stb,
    input logic [NUM_SUB*DATA_W-1:0] sub_r_data
);
    logic in_any;

    // Range test independent of the decoder's bit masking
    always_comb begin
        in_any = 1'b0;
        for (int i = 0; i < NUM_SUB; i++) begin
            if (33'(up_addr) >= 33'(SUB_BASE[i*ADDR_W +: ADDR_W]) &&
                33'(up_addr) <  33'(SUB_BASE[i*ADDR_W +: ADDR_W]) + (33'd1 << WIN_AW))
                in_any = 1'b1;
        end
    end

    always_comb begin
        assert_rstb_onehot_R7: assert ($onehot0(sub_r_stb))
            else $error("more than one read strobe");
        assert_wstb_onehot_R7: assert ($onehot0(sub_w_stb))
            else $error("more than one write strobe");
        assert_rstb_source_R1: assert (sub_r_stb == '0 || up_r_stb)
            else $error("read strobe without upstream read");
        assert_wstb_source_R2: assert (sub_w_stb == '0 || up_w_stb)
            else $error("write strobe without upstream write");
        assert_unmapped_quiet_R5: assert (in_any || (sub_r_stb == '0 && sub_w_stb == '0))
            else $error("strobe raised for unmapped address");
        assert_rdata_zero_R6: assert (sub_r_data != '0 || up_r_data == '0)
            else $error("read data without any source");
        for (int i = 0; i < NUM_SUB; i++) begin
            if (sub_r_stb[i] || sub_w_stb[i]) begin
                assert_offset_R3: assert (
                    sub_addr[i*WIN_AW +: WIN_AW] ==
                    WIN_AW'(up_addr - SUB_BASE[i*ADDR_W +: ADDR_W]))
                    else $error("offset mismatch");
            end
        end
    end
endmodule

bind regdec_top regdec_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_SUB (NUM_SUB),
    .WIN_AW  (WIN_AW),
    .SUB_BASE(SUB_BASE)
) u_regdec_chk (
    .up_addr   (up_addr),
    .up_r_stb  (up_r_stb),
    .up_w_stb  (up_w_stb),
    .up_r_data (up_r_data),
    .sub_addr  (sub_addr),
    .sub_r_stb (sub_r_stb),
    .sub_w_stb (sub_w_stb),
    .sub_r_data(sub_r_data)
);

// File: tb/tb_regdec_top.sv
module tb_reg_stub #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          r_stb,
    input  logic          w_stb,
    input  logic [DW-1:0] w_data,
    output logic [DW-1:0] r_data
);
    logic [DW-1:0] mem [16];
    always_ff @(posedge clk) begin
        if (rst) begin
            r_data <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            r_data <= r_stb ? mem[addr[3:0]] : '0;
            if (w_stb) mem[addr[3:0]] <= w_data;
        end
    end
endmodule

module tb_regdec_top;
    localparam int AW = 16, DW = 8, NS = 2, WA = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [AW-1:0]    up_addr = '0;
    logic             up_r_stb = 1'b0, up_w_stb = 1'b0;
    logic [DW-1:0]    up_w_data = '0;
    logic [DW-1:0]    up_r_data;
    logic [NS*WA-1:0] sub_addr;
    logic [NS-1:0]    sub_r_stb, sub_w_stb;
    logic [NS*DW-1:0] sub_w_data, sub_r_data;

    regdec_top dut (
        .up_addr(up_addr), .up_r_stb(up_r_stb), .up_w_stb(up_w_stb),
        .up_w_data(up_w_data), .up_r_data(up_r_data), .sub_addr(sub_addr),
        .sub_r_stb(sub_r_stb), .sub_w_stb(sub_w_stb), .sub_w_data(sub_w_data),
        .sub_r_data(sub_r_data)
    );

    for (genvar i = 0; i < NS; i++) begin : g_stub
        tb_reg_stub #(.AW(WA), .DW(DW)) u_stub (
            .clk(clk), .rst(rst), .addr(sub_addr[i*WA +: WA]),
            .r_stb(sub_r_stb[i]), .w_stb(sub_w_stb[i]),
            .w_data(sub_w_data[i*DW +: DW]), .r_data(sub_r_data[i*DW +: DW])
        );
    end

    int checks = 0, errors = 0;
    logic [DW-1:0] model [NS][16];
    logic [DW-1:0] exp_rd = '0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Window index from the requirement map, -1 when unmapped
    function automatic int exp_sel(input logic [AW-1:0] a);
        if (a < 16'h1000) return 0;
        if (a < 16'h2000) return 1;
        return -1;
    endfunction

    function automatic logic [AW-1:0] exp_base(input int s);
        return (s == 1) ? 16'h1000 : 16'h0000;
    endfunction

    task automatic step(input logic [AW-1:0] a, input bit rd, input bit wr, input logic [DW-1:0] d);
        int s;
        logic [NS-1:0] er, ew;
        @(negedge clk);
        chk(up_r_data == exp_rd, "R6 read data one cycle after strobe", 32'(up_r_data), 32'(exp_rd));
        up_addr = a; up_r_stb = rd; up_w_stb = wr; up_w_data = d;
        #1;
        s  = exp_sel(a);
        er = (rd && s >= 0) ? NS'(1 << s) : '0;
        ew = (wr && s >= 0) ? NS'(1 << s) : '0;
        chk(sub_r_stb == er, s < 0 ? "R5 no read strobe unmapped" : "R1 read strobe routing",
            32'(sub_r_stb), 32'(er));
        chk(sub_w_stb == ew, s < 0 ? "R5 no write strobe unmapped" : "R2 write strobe routing",
            32'(sub_w_stb), 32'(ew));
        chk($countones(sub_r_stb) <= 1 && $countones(sub_w_stb) <= 1, "R7 one strobe at most",
            32'({sub_r_stb, sub_w_stb}), 32'(0));
        if (s >= 0)
            chk(sub_addr[s*WA +: WA] == WA'(a - exp_base(s)), "R3 offset stripped",
                32'(sub_addr[s*WA +: WA]), 32'(WA'(a - exp_base(s))));
        for (int i = 0; i < NS; i++)
            chk(sub_w_data[i*DW +: DW] == d, "R4 write data broadcast",
                32'(sub_w_data[i*DW +: DW]), 32'(d));
        exp_rd = (rd && s >= 0) ? model[s][a[3:0]] : '0;
        if (wr && s >= 0) model[s][a[3:0]] = d;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < NS; i++)
            for (int j = 0; j < 16; j++) model[i][j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(up_r_data == '0, "R6 reset read data zero", 32'(up_r_data), 0);
        chk(sub_r_stb == '0 && sub_w_stb == '0, "R1 idle no strobes",
            32'({sub_r_stb, sub_w_stb}), 0);
        // Directed corners: window edges and unmapped space
        step(16'h0FFF, 1'b0, 1'b1, 8'hA1);
        step(16'h1000, 1'b0, 1'b1, 8'hB2);
        step(16'h0FFF, 1'b1, 1'b0, 8'h00);
        step(16'h1000, 1'b1, 1'b0, 8'h00);
        step(16'h200F, 1'b0, 1'b1, 8'hEE);
        step(16'h100F, 1'b1, 1'b0, 8'h00);
        step(16'h2000, 1'b1, 1'b0, 8'h00);
        step(16'hFFFF, 1'b1, 1'b1, 8'h77);
        step(16'h1FFF, 1'b1, 1'b1, 8'h5C);
        step(16'h1FFF, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        // Random traffic across both windows and unmapped space
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a;
            int region;
            region = int'($urandom % 4);
            a = AW'(region * 16'h1000) | AW'($urandom % ((n % 3 == 0) ? 4096 : 16));
            if (region == 3) a = AW'($urandom) | 16'h2000;
            step(a, 1'($urandom), 1'($urandom), DW'($urandom));
        end
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule